// File: doc/BRIEF.md
# Compare-Match Timer Output Unit

This unit is a free-running 10-bit up-counter with two comparators. Comparator A watches a full-width match value. Comparator P watches a 3-bit period value, which is compared against the counter's top three bits while the low seven bits are zero. Software sets up the unit through static register-style inputs: enable, a 2-bit mode field, a clear-source select, a 2-bit pin-action field and an initial pin level. The unit drives one output pin and two sticky request flags. Each flag is cleared by its own one-cycle clear pulse.

In compare-match mode the counter restarts on the clock after it reaches the selected compare value. With the P clear source and a P value of zero, the counter instead runs through all 1024 counts and wraps. Each A match applies the pin action to the pin. A P match never touches the pin. A rising edge of the enable input loads the pin with the initial level. The other mode codes leave the pin untouched and raise no flags.

Top module: `cmt_unit`

## Requirements
- R1: While `en` is low the counter reads 0 and neither flag gets set.
- R2: On the first clock where `en` is high after being low, `pin_o` takes the value of `init_lvl` and the counter advances to 1.
- R3: With `mode`=00 and `clr_sel`=0 and a nonzero `cmp_p`, the counter reaches `cmp_p`*128 and reads 0 on the next clock, and `flag_p` is set on that clock.
- R4: With `clr_sel`=0 and `cmp_p`=0, the counter counts up to 1023 and then wraps to 0, and `flag_p` is set on the wrap.
- R5: With `clr_sel`=1 the counter reads 0 on the clock after it equals `cmp_a`, and `flag_p` is never set, even when `cmp_p`*128 is below `cmp_a`.
- R6: A `cmp_a` value of 0 gives no A match: `flag_a` stays clear and `pin_o` does not change.
- R7: On the clock after the counter equals a nonzero `cmp_a`, `flag_a` is set and `pin_o` follows `pin_act`: 00 leaves it unchanged, 01 drives it low, 10 drives it high and 11 inverts it.
- R8: A P match has no effect on `pin_o`.
- R9: A flag stays set until its clear input is high at a clock edge. If a match and the clear arrive at the same edge, the flag ends up set.
- R10: With a `mode` value other than 00 the counter still runs and wraps, but `pin_o` holds and neither flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counter enable; a rising edge loads the pin |
| mode | input | 2 | Operating mode; 00 is compare-match |
| clr_sel | input | 1 | Clear source: 0 = comparator P, 1 = comparator A |
| pin_act | input | 2 | Pin action on an A match |
| init_lvl | input | 1 | Pin level loaded when enable rises |
| cmp_a | input | 10 | Comparator A value |
| cmp_p | input | 3 | Comparator P value (counter top bits) |
| flag_a_clr | input | 1 | Clears `flag_a` |
| flag_p_clr | input | 1 | Clears `flag_p` |
| cnt_o | output | 10 | Counter value |
| pin_o | output | 1 | Output pin |
| flag_a | output | 1 | Sticky A-match flag |
| flag_p | output | 1 | Sticky P-match flag |

## Verification
Two flag events can fall on the same edge: a match that sets a flag, and a software clear pulse aimed at that flag. The bench first clears `flag_a`. It then waits until the counter shows the A value and raises `flag_a_clr` for exactly the edge on which the match takes effect. It judges the result by reading `flag_a` one cycle later, where the set must have won. A separate clear pulse on a quiet edge must then drop the flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  localparam logic [1:0] MODE_CMP = 2'b00;

  // pin level after an A-match event
  function automatic logic pin_next(input pin_act_e act, input logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr_req,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!en)     cnt <= '0;
    else if (clr_req) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  // R1
  held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));

  // R3
  clear_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr_req) |=> (cnt == '0));
endmodule

// File: rtl/cmt_match.sv
module cmt_match
  import cmt_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             clr_sel,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  input  logic [CNT_W-1:0] cnt,
  output logic             a_hit,
  output logic             p_hit,
  output logic             p_flag_set,
  output logic             clr_req
);
  localparam int LOW_W = CNT_W - PER_W;

  // count at which the P period ends; zero means a full wrap
  function automatic logic [CNT_W-1:0] p_target(input logic [PER_W-1:0] p);
    if (p == '0) return '1;
    return {p, {LOW_W{1'b0}}};
  endfunction

  logic cmp_mode;
  assign cmp_mode   = en && (mode == MODE_CMP);
  assign a_hit      = cmp_mode && (cmp_a != '0) && (cnt == cmp_a);
  assign p_hit      = cmp_mode && (cnt == p_target(cmp_p));
  assign p_flag_set = p_hit && !clr_sel;
  assign clr_req    = clr_sel ? a_hit : p_hit;
endmodule

// File: rtl/cmt_flag.sv
module cmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/cmt_pin.sv
module cmt_pin
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       a_hit,
  input  logic [1:0] act,
  input  logic       init_lvl,
  output logic       pin
);
  logic en_q;
  logic en_rise;

  assign en_rise = en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pin  <= 1'b0;
    end else begin
      en_q <= en;
      if (en_rise)    pin <= init_lvl;
      else if (a_hit) pin <= pin_next(pin_act_e'(act), pin);
    end
  end

  // R8
  pin_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin) |-> ($past(a_hit) || $past(en_rise)));

  // R2
  pin_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (pin == $past(init_lvl)));
endmodule

// File: rtl/cmt_unit.sv
module cmt_unit #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       mode,
  input  logic             clr_sel,
  input  logic [1:0]       pin_act,
  input  logic             init_lvl,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [PER_W-1:0] cmp_p,
  input  logic             flag_a_clr,
  input  logic             flag_p_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pin_o,
  output logic             flag_a,
  output logic             flag_p
);
  logic a_hit;
  logic p_hit;
  logic p_flag_set;
  logic clr_req;

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .clr_req(clr_req), .cnt(cnt_o)
  );

  cmt_match #(.CNT_W(CNT_W), .PER_W(PER_W)) u_match (
    .en(en), .mode(mode), .clr_sel(clr_sel), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .cnt(cnt_o), .a_hit(a_hit), .p_hit(p_hit), .p_flag_set(p_flag_set),
    .clr_req(clr_req)
  );

  cmt_flag u_flag_a (
    .clk(clk), .rst_n(rst_n), .set(a_hit), .clr(flag_a_clr), .flag(flag_a)
  );

  cmt_flag u_flag_p (
    .clk(clk), .rst_n(rst_n), .set(p_flag_set), .clr(flag_p_clr), .flag(flag_p)
  );

  cmt_pin u_pin (
    .clk(clk), .rst_n(rst_n), .en(en), .a_hit(a_hit), .act(pin_act),
    .init_lvl(init_lvl), .pin(pin_o)
  );

  // R5
  no_p_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_p) |-> $past(!clr_sel && en));

  // R6
  no_zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> $past(cmp_a != '0));

  // R10
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> (!$rose(flag_a) && !$rose(flag_p)));
endmodule

// File: tb/cmt_unit_bench.sv
module cmt_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       clr_sel = 1'b0;
  logic [1:0] pin_act = 2'b00;
  logic       init_lvl = 1'b0;
  logic [9:0] cmp_a = 10'd1;
  logic [2:0] cmp_p = 3'd1;
  logic       flag_a_clr = 1'b0;
  logic       flag_p_clr = 1'b0;
  logic [9:0] cnt_o;
  logic       pin_o;
  logic       flag_a;
  logic       flag_p;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_unit u_cmt_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .clr_sel(clr_sel),
    .pin_act(pin_act), .init_lvl(init_lvl), .cmp_a(cmp_a), .cmp_p(cmp_p),
    .flag_a_clr(flag_a_clr), .flag_p_clr(flag_p_clr), .cnt_o(cnt_o),
    .pin_o(pin_o), .flag_a(flag_a), .flag_p(flag_p)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input string req, input int v);
    int i;
    for (i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (cnt_o == 10'(v)) break;
    end
    if (i == 2000) check(req, int'(cnt_o), v);
  endtask

  // configure while disabled, clear flags, then enable
  task automatic start(input logic [1:0] m, input logic cs, input logic [1:0] act,
                       input logic il, input int a, input int p);
    @(negedge clk);
    en = 1'b0; mode = m; clr_sel = cs; pin_act = act; init_lvl = il;
    cmp_a = 10'(a); cmp_p = 3'(p);
    flag_a_clr = 1'b1; flag_p_clr = 1'b1;
    @(negedge clk);
    flag_a_clr = 1'b0; flag_p_clr = 1'b0;
    en = 1'b1;
    @(negedge clk);
    check("R2 pin loaded on enable", int'(pin_o), int'(il));
    check("R2 counter at 1", int'(cnt_o), 1);
  endtask

  task automatic t_disabled;
    @(negedge clk);
    en = 1'b0; cmp_a = 10'd1; cmp_p = 3'd0;
    repeat (5) @(negedge clk);
    check("R1 counter held", int'(cnt_o), 0);
    check("R1 flag_a clear", int'(flag_a), 0);
    check("R1 flag_p clear", int'(flag_p), 0);
  endtask

  task automatic t_clear_on_p;
    start(2'b00, 1'b0, 2'b10, 1'b0, 50, 1);
    wait_cnt("R7 reach A", 50);
    @(negedge clk);
    check("R7 pin high on A", int'(pin_o), 1);
    check("R7 flag_a set", int'(flag_a), 1);
    check("R3 no clear on A", int'(cnt_o), 51);
    wait_cnt("R3 reach P", 128);
    @(negedge clk);
    check("R3 cleared after P", int'(cnt_o), 0);
    check("R3 flag_p set", int'(flag_p), 1);
    check("R8 pin unchanged by P", int'(pin_o), 1);
  endtask

  task automatic t_full_wrap;
    start(2'b00, 1'b0, 2'b00, 1'b0, 1000, 0);
    wait_cnt("R4 reach 1023", 1023);
    check("R4 no early P flag", int'(flag_p), 0);
    @(negedge clk);
    check("R4 wrapped", int'(cnt_o), 0);
    check("R4 flag_p on wrap", int'(flag_p), 1);
  endtask

  task automatic t_clear_on_a;
    start(2'b00, 1'b1, 2'b00, 1'b0, 200, 1);
    wait_cnt("R5 reach A", 200);
    @(negedge clk);
    check("R5 cleared after A", int'(cnt_o), 0);
    check("R5 flag_a set", int'(flag_a), 1);
    check("R5 flag_p not set", int'(flag_p), 0);
    wait_cnt("R5 reach A again", 200);
    @(negedge clk);
    check("R5 flag_p still clear", int'(flag_p), 0);
  endtask

  task automatic t_zero_a;
    start(2'b00, 1'b0, 2'b11, 1'b1, 0, 1);
    repeat (300) @(negedge clk);
    check("R6 flag_a clear", int'(flag_a), 0);
    check("R6 pin unchanged", int'(pin_o), 1);
    check("R6 P still clears", int'(flag_p), 1);
  endtask

  task automatic t_actions;
    start(2'b00, 1'b1, 2'b11, 1'b0, 10, 0);
    wait_cnt("R7 toggle", 10);
    @(negedge clk);
    check("R7 toggle first", int'(pin_o), 1);
    wait_cnt("R7 toggle", 10);
    @(negedge clk);
    check("R7 toggle second", int'(pin_o), 0);
    start(2'b00, 1'b1, 2'b01, 1'b1, 10, 0);
    wait_cnt("R7 low", 10);
    @(negedge clk);
    check("R7 drive low", int'(pin_o), 0);
    start(2'b00, 1'b1, 2'b00, 1'b1, 10, 0);
    wait_cnt("R7 hold", 10);
    @(negedge clk);
    check("R7 no change", int'(pin_o), 1);
    check("R7 flag on hold", int'(flag_a), 1);
  endtask

  task automatic t_flag_collide;
    start(2'b00, 1'b1, 2'b00, 1'b0, 20, 0);
    wait_cnt("R9 reach A", 20);
    check("R9 flag clear before", int'(flag_a), 0);
    flag_a_clr = 1'b1;
    @(negedge clk);
    flag_a_clr = 1'b0;
    check("R9 set beats clear", int'(flag_a), 1);
    flag_a_clr = 1'b1;
    @(negedge clk);
    flag_a_clr = 1'b0;
    check("R9 clear drops flag", int'(flag_a), 0);
    @(negedge clk);
    check("R9 stays clear", int'(flag_a), 0);
  endtask

  task automatic t_other_mode;
    start(2'b01, 1'b1, 2'b11, 1'b1, 10, 1);
    wait_cnt("R10 pass A", 11);
    wait_cnt("R10 wrap", 0);
    check("R10 pin held", int'(pin_o), 1);
    check("R10 flag_a clear", int'(flag_a), 0);
    check("R10 flag_p clear", int'(flag_p), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset counter", int'(cnt_o), 0);
    check("R1 reset pin", int'(pin_o), 0);
    rst_n = 1'b1;
    t_disabled();
    t_clear_on_p();
    t_full_wrap();
    t_clear_on_a();
    t_zero_a();
    t_actions();
    t_flag_collide();
    t_other_mode();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule